// File: doc/BRIEF.md
# Trap-Time Instruction Namespace Switcher

This block keeps the instruction-set namespace value under which the core decodes opcodes, and changes it in hardware whenever a trap is taken or a trap return executes. Each privilege level owns a save slot for the namespace that was active when the level was entered, a handler namespace, and a table base. Taking a trap into a level stores the running namespace in that level's save slot. The handler namespace then comes either from the level's own register or, when the level's table base is non-zero, from a per-cause entry fetched over a simple memory read port. A trap return puts back the namespace saved by the level being left, in the same cycle as the privilege change.

The pipeline sends one-cycle strobes for trap entry (target level and cause) and for trap return (target level). It watches `busy` so that it issues no handler instruction while a table fetch is outstanding. Software reaches every register through an indexed CSR port. The number of levels is three, or four when the hypervisor option is set. The table bases can also be removed entirely at elaboration, which takes all memory traffic out of trap entry.

Top module: `isans_trap_switch`

## Requirements
- R1: After reset the current namespace, every save slot, every handler namespace and every table base read zero, `cur_priv` equals LEVELS-1 (2 by default), and `busy` and `mem_req` are low.
- R2: An accepted trap entry sets `cur_priv` to the trap level at the next edge and copies the namespace that was current into that level's save slot, even when the two values are already equal.
- R3: When the target level's table base is zero, the trap entry loads `cur_ns` from that level's handler namespace at the same edge, and `mem_req` stays low.
- R4: When the target level's table base is non-zero, `mem_req` and `busy` rise at the next edge with `mem_addr` = base + 4 * cause. They stay high with `mem_addr` held until a cycle with `mem_ack` high. At that edge `cur_ns` takes `mem_rdata` and `busy` falls.
- R5: An accepted trap return loads `cur_ns` from the save slot of the level in `cur_priv` and sets `cur_priv` to the return level, both at the same edge, with no comparison of the values.
- R6: When trap entry and trap return are strobed in the same cycle, only the trap entry takes effect.
- R7: While `busy` is high, trap strobes, return strobes and CSR writes are ignored, and `cur_ns` and `cur_priv` hold until the fetch completes.
- R8: An accepted trap entry or trap return in the same cycle as a CSR write causes the write to be dropped.
- R9: `csr_addr[3:2]` selects the register kind (0 current namespace, 1 save slot, 2 handler namespace, 3 table base) and `csr_addr[1:0]` selects the level. Namespaces read zero-extended, and reads take effect in the same cycle. A level index of LEVELS or more reads zero and ignores writes. An event strobe that names such a level is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_valid | input | 1 | Trap-entry strobe |
| trap_level | input | 2 | Privilege level the trap enters |
| trap_cause | input | CAUSE_W | Cause number of the trap |
| ret_valid | input | 1 | Trap-return strobe |
| ret_level | input | 2 | Privilege level the return goes to |
| csr_we | input | 1 | CSR write enable |
| csr_addr | input | 4 | CSR index: kind in [3:2], level in [1:0] |
| csr_wdata | input | ADDR_W | CSR write data |
| csr_rdata | output | ADDR_W | CSR read data for csr_addr |
| mem_req | output | 1 | Table fetch request, held until acknowledged |
| mem_addr | output | ADDR_W | Table entry address |
| mem_ack | input | 1 | Read data valid for the pending fetch |
| mem_rdata | input | NS_W | Namespace value returned by memory |
| busy | output | 1 | High while a table fetch is pending |
| cur_ns | output | NS_W | Current instruction namespace |
| cur_priv | output | 2 | Current privilege level |

## Verification
The bench traps into a level whose handler namespace already equals the running one, then overwrites the save slot before returning. A design that skipped "redundant" swaps would return the stale value instead of the written one. It runs a table fetch that is left unacknowledged for several cycles while a return strobe and a CSR write arrive. A design that did not freeze would change privilege, move `mem_addr` or lose the handler-namespace value. It also drives colliding strobes: trap with return, and event with CSR write. Here a wrong priority shows up as the return level or the written data appearing on the outputs. Finally it uses the largest cause number and an out-of-range level, which catch a misplaced address shift and a bank written past its last level.

// File: rtl/isw_pkg.sv
package isw_pkg;
   localparam int LVL_W     = 2;
   localparam int MAX_LVLS  = 4;
   localparam int CSR_AW    = 4;

   typedef enum logic [1:0] {
      KIND_CUR  = 2'd0,
      KIND_PREV = 2'd1,
      KIND_TRAP = 2'd2,
      KIND_BASE = 2'd3
   } csr_kind_e;

   typedef struct packed {
      csr_kind_e        kind;
      logic [LVL_W-1:0] lvl;
   } csr_sel_t;
endpackage

// File: rtl/isw_level_bank.sv
module isw_level_bank
   import isw_pkg::*;
#(
   parameter int NS_W     = 8,
   parameter int ADDR_W   = 16,
   parameter bit TABLE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              save_en,
   input  logic [NS_W-1:0]   save_ns,
   input  logic              wr_en,
   input  csr_kind_e         wr_kind,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [NS_W-1:0]   prev_q,
   output logic [NS_W-1:0]   trap_q,
   output logic [ADDR_W-1:0] base_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            prev_q <= '0;
      else if (save_en)                      prev_q <= save_ns;
      else if (wr_en && wr_kind == KIND_PREV) prev_q <= wr_data[NS_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            trap_q <= '0;
      else if (wr_en && wr_kind == KIND_TRAP) trap_q <= wr_data[NS_W-1:0];
   end

   generate
      if (TABLE_EN) begin : g_base
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            base_q <= '0;
            else if (wr_en && wr_kind == KIND_BASE) base_q <= wr_data;
         end
      end else begin : g_nobase
         assign base_q = '0;
      end
   endgenerate
endmodule

// File: rtl/isw_table_fetch.sv
module isw_table_fetch #(
   parameter int ADDR_W  = 16,
   parameter int CAUSE_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  base,
   input  logic [CAUSE_W-1:0] cause,
   input  logic               mem_ack,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               done
);
   localparam int ENTRY_SHIFT = 2;

   logic [ADDR_W-1:0] entry_off;
   assign entry_off = ADDR_W'(cause) << ENTRY_SHIFT;
   assign done      = mem_req && mem_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req  <= 1'b0;
         mem_addr <= '0;
      end else if (start) begin
         mem_req  <= 1'b1;
         mem_addr <= base + entry_off;
      end else if (done) begin
         mem_req  <= 1'b0;
      end
   end
endmodule

// File: rtl/isans_trap_switch.sv
module isans_trap_switch
   import isw_pkg::*;
#(
   parameter int NS_W     = 8,
   parameter int ADDR_W   = 16,
   parameter int CAUSE_W  = 5,
   parameter bit HYP_EN   = 1'b0,
   parameter bit TABLE_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trap_valid,
   input  logic [1:0]         trap_level,
   input  logic [CAUSE_W-1:0] trap_cause,
   input  logic               ret_valid,
   input  logic [1:0]         ret_level,
   input  logic               csr_we,
   input  logic [3:0]         csr_addr,
   input  logic [ADDR_W-1:0]  csr_wdata,
   output logic [ADDR_W-1:0]  csr_rdata,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic               mem_ack,
   input  logic [NS_W-1:0]    mem_rdata,
   output logic               busy,
   output logic [NS_W-1:0]    cur_ns,
   output logic [1:0]         cur_priv
);
   localparam int LEVELS = HYP_EN ? 4 : 3;
   localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

   initial begin
      assert (ADDR_W >= NS_W) else $error("ADDR_W must hold a namespace");
      assert (ADDR_W >= CAUSE_W + 2) else $error("ADDR_W too small for cause offset");
      assert (NS_W > 0) else $error("NS_W must be positive");
   end

   csr_sel_t          sel;
   logic              trap_lvl_ok, ret_lvl_ok, csr_lvl_ok;
   logic              trap_go, ret_go, csr_go;
   logic              use_table, fetch_done;
   logic [NS_W-1:0]   prev_arr [MAX_LVLS];
   logic [NS_W-1:0]   trap_arr [MAX_LVLS];
   logic [ADDR_W-1:0] base_arr [MAX_LVLS];

   assign sel         = csr_sel_t'(csr_addr);
   assign trap_lvl_ok = int'(trap_level) < LEVELS;
   assign ret_lvl_ok  = int'(ret_level) < LEVELS;
   assign csr_lvl_ok  = int'(sel.lvl) < LEVELS;

   assign trap_go = trap_valid && !busy && trap_lvl_ok;
   assign ret_go  = ret_valid && !busy && ret_lvl_ok && !trap_go;
   assign csr_go  = csr_we && !busy && !trap_go && !ret_go;

   genvar i;
   generate
      for (i = 0; i < MAX_LVLS; i++) begin : g_lvl
         if (i < LEVELS) begin : g_live
            isw_level_bank #(
               .NS_W(NS_W), .ADDR_W(ADDR_W), .TABLE_EN(TABLE_EN)
            ) u_bank (
               .clk     (clk),
               .rst_n   (rst_n),
               .save_en (trap_go && trap_level == LVL_W'(i)),
               .save_ns (cur_ns),
               .wr_en   (csr_go && sel.lvl == LVL_W'(i) && sel.kind != KIND_CUR),
               .wr_kind (sel.kind),
               .wr_data (csr_wdata),
               .prev_q  (prev_arr[i]),
               .trap_q  (trap_arr[i]),
               .base_q  (base_arr[i])
            );
         end else begin : g_absent
            assign prev_arr[i] = '0;
            assign trap_arr[i] = '0;
            assign base_arr[i] = '0;
         end
      end
   endgenerate

   assign use_table = base_arr[trap_level] != '0;

   isw_table_fetch #(
      .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W)
   ) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (trap_go && use_table),
      .base     (base_arr[trap_level]),
      .cause    (trap_cause),
      .mem_ack  (mem_ack),
      .mem_req  (mem_req),
      .mem_addr (mem_addr),
      .done     (fetch_done)
   );

   assign busy = mem_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cur_ns <= '0;
      else if (trap_go && !use_table)      cur_ns <= trap_arr[trap_level];
      else if (fetch_done)                 cur_ns <= mem_rdata;
      else if (ret_go)                     cur_ns <= prev_arr[cur_priv];
      else if (csr_go && sel.kind == KIND_CUR) cur_ns <= csr_wdata[NS_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cur_priv <= TOP_LVL;
      else if (trap_go) cur_priv <= trap_level;
      else if (ret_go)  cur_priv <= ret_level;
   end

   always_comb begin
      csr_rdata = '0;
      unique case (sel.kind)
         KIND_CUR:  csr_rdata = ADDR_W'(cur_ns);
         KIND_PREV: if (csr_lvl_ok) csr_rdata = ADDR_W'(prev_arr[sel.lvl]);
         KIND_TRAP: if (csr_lvl_ok) csr_rdata = ADDR_W'(trap_arr[sel.lvl]);
         KIND_BASE: if (csr_lvl_ok) csr_rdata = base_arr[sel.lvl];
         default:   csr_rdata = '0;
      endcase
   end
endmodule

// File: rtl/isw_checker.sv
module isw_checker #(
   parameter int NS_W    = 8,
   parameter int ADDR_W  = 16,
   parameter int CAUSE_W = 5,
   parameter bit HYP_EN  = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trap_valid,
   input logic [1:0]        trap_level,
   input logic              ret_valid,
   input logic [1:0]        ret_level,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack,
   input logic [NS_W-1:0]   mem_rdata,
   input logic              busy,
   input logic [NS_W-1:0]   cur_ns,
   input logic [1:0]        cur_priv
);
   localparam int LEVELS = HYP_EN ? 4 : 3;

   logic trap_in, ret_in;
   assign trap_in = trap_valid && !busy && int'(trap_level) < LEVELS;
   assign ret_in  = ret_valid && !busy && int'(ret_level) < LEVELS;

   AST_TRAP_SETS_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
      trap_in |=> cur_priv == $past(trap_level)); // R2

   AST_RET_SETS_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_in && !trap_valid) |=> cur_priv == $past(ret_level)); // R5

   AST_TRAP_OVER_RET: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_in && ret_in && trap_level != ret_level) |=> cur_priv != $past(ret_level)); // R6

   AST_BUSY_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_ack) |=> busy && mem_req && $stable(cur_ns) && $stable(cur_priv) && $stable(mem_addr)); // R7

   AST_FETCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mem_ack) |=> !busy && cur_ns == $past(mem_rdata)); // R4

   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !trap_valid) |=> !mem_req); // R3
endmodule

bind isans_trap_switch isw_checker #(
   .NS_W(NS_W), .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .HYP_EN(HYP_EN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .trap_valid (trap_valid),
   .trap_level (trap_level),
   .ret_valid  (ret_valid),
   .ret_level  (ret_level),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_ack    (mem_ack),
   .mem_rdata  (mem_rdata),
   .busy       (busy),
   .cur_ns     (cur_ns),
   .cur_priv   (cur_priv)
);

// File: tb/isans_trap_switch_tb.sv
module isans_trap_switch_tb;
   localparam int NS_W = 8;
   localparam int ADDR_W = 16;
   localparam int CAUSE_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trap_valid = 1'b0;
   logic [1:0] trap_level = '0;
   logic [CAUSE_W-1:0] trap_cause = '0;
   logic ret_valid = 1'b0;
   logic [1:0] ret_level = '0;
   logic csr_we = 1'b0;
   logic [3:0] csr_addr = '0;
   logic [ADDR_W-1:0] csr_wdata = '0;
   logic [ADDR_W-1:0] csr_rdata;
   logic mem_req;
   logic [ADDR_W-1:0] mem_addr;
   logic mem_ack = 1'b0;
   logic [NS_W-1:0] mem_rdata = '0;
   logic busy;
   logic [NS_W-1:0] cur_ns;
   logic [1:0] cur_priv;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   isans_trap_switch #(.NS_W(NS_W), .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .trap_valid(trap_valid), .trap_level(trap_level), .trap_cause(trap_cause),
      .ret_valid(ret_valid), .ret_level(ret_level),
      .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .busy(busy), .cur_ns(cur_ns), .cur_priv(cur_priv)
   );

   // CSR index encoding: {kind[1:0], level[1:0]}
   function automatic logic [3:0] ix(input int kind, input int lvl);
      return {2'(kind), 2'(lvl)};
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic csr_wr(input logic [3:0] a, input int d);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = a; csr_wdata = ADDR_W'(d);
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic csr_rd(input logic [3:0] a, output int d);
      @(negedge clk);
      csr_addr = a;
      #1 d = int'(csr_rdata);
   endtask

   task automatic do_trap(input int lvl, input int cause);
      @(negedge clk);
      trap_valid = 1'b1; trap_level = 2'(lvl); trap_cause = CAUSE_W'(cause);
      @(negedge clk);
      trap_valid = 1'b0;
   endtask

   task automatic do_ret(input int lvl);
      @(negedge clk);
      ret_valid = 1'b1; ret_level = 2'(lvl);
      @(negedge clk);
      ret_valid = 1'b0;
   endtask

   task automatic t_reset;
      int d;
      check("R1", "cur_ns", cur_ns, 0);
      check("R1", "cur_priv", cur_priv, 2);
      check("R1", "busy", busy, 0);
      check("R1", "mem_req", mem_req, 0);
      csr_rd(ix(1, 0), d); check("R1", "prev0", d, 0);
      csr_rd(ix(2, 1), d); check("R1", "trap1", d, 0);
      csr_rd(ix(3, 2), d); check("R1", "base2", d, 0);
   endtask

   task automatic t_csr_map;
      int d;
      csr_wr(ix(2, 0), 'h11);
      csr_wr(ix(2, 1), 'h22);
      csr_wr(ix(2, 2), 'h33);
      csr_rd(ix(2, 0), d); check("R9", "trap0 readback", d, 'h11);
      csr_rd(ix(2, 1), d); check("R9", "trap1 readback", d, 'h22);
      csr_rd(ix(2, 2), d); check("R9", "trap2 readback", d, 'h33);
      csr_wr(ix(2, 3), 'h55);
      csr_rd(ix(2, 3), d); check("R9", "absent level reads zero", d, 0);
      csr_wr(ix(1, 0), 'h44);
      csr_rd(ix(1, 0), d); check("R9", "prev0 readback", d, 'h44);
      csr_wr(ix(0, 0), 'h0A);
      check("R9", "cur_ns after CSR write", cur_ns, 'h0A);
      csr_rd(ix(0, 0), d); check("R9", "cur readback", d, 'h0A);
   endtask

   task automatic t_trap_direct;
      int d;
      do_trap(1, 3);
      check("R3", "cur_ns from handler ns", cur_ns, 'h22);
      check("R2", "cur_priv", cur_priv, 1);
      check("R3", "no mem_req", mem_req, 0);
      csr_rd(ix(1, 1), d); check("R2", "prev1 saved", d, 'h0A);
   endtask

   task automatic t_ret;
      do_ret(0);
      check("R5", "cur_ns restored", cur_ns, 'h0A);
      check("R5", "cur_priv", cur_priv, 0);
   endtask

   task automatic t_trap_equal;
      int d;
      csr_wr(ix(0, 0), 'h22);
      do_trap(1, 0);
      csr_rd(ix(1, 1), d); check("R2", "prev1 saved though equal", d, 'h22);
      check("R2", "cur_ns", cur_ns, 'h22);
      csr_wr(ix(1, 1), 'h77);
      do_ret(2);
      check("R5", "restore without compare", cur_ns, 'h77);
      check("R5", "cur_priv", cur_priv, 2);
   endtask

   task automatic t_table;
      int d;
      csr_wr(ix(3, 2), 'h0100);
      do_trap(2, 5);
      check("R4", "busy", busy, 1);
      check("R4", "mem_req", mem_req, 1);
      check("R4", "mem_addr", mem_addr, 'h0114);
      check("R4", "cur_ns held", cur_ns, 'h77);
      // stimulus while busy: must be ignored (R7)
      @(negedge clk);
      ret_valid = 1'b1; ret_level = 2'd0;
      csr_we = 1'b1; csr_addr = ix(2, 0); csr_wdata = 'h99;
      @(negedge clk);
      ret_valid = 1'b0; csr_we = 1'b0;
      check("R7", "priv held", cur_priv, 2);
      check("R7", "cur_ns held", cur_ns, 'h77);
      check("R7", "mem_addr held", mem_addr, 'h0114);
      check("R7", "still busy", busy, 1);
      @(negedge clk);
      mem_ack = 1'b1; mem_rdata = 'h5C;
      @(negedge clk);
      mem_ack = 1'b0;
      check("R4", "cur_ns from table", cur_ns, 'h5C);
      check("R4", "busy cleared", busy, 0);
      check("R4", "mem_req cleared", mem_req, 0);
      csr_rd(ix(2, 0), d); check("R7", "CSR write dropped", d, 'h11);
      csr_rd(ix(1, 2), d); check("R2", "prev2 saved", d, 'h77);
      csr_wr(ix(3, 2), 0);
   endtask

   task automatic t_same_cycle;
      int d;
      @(negedge clk);
      trap_valid = 1'b1; trap_level = 2'd0; trap_cause = 5'd1;
      ret_valid = 1'b1; ret_level = 2'd1;
      @(negedge clk);
      trap_valid = 1'b0; ret_valid = 1'b0;
      check("R6", "priv follows trap", cur_priv, 0);
      check("R6", "cur_ns follows trap", cur_ns, 'h11);
      csr_rd(ix(1, 0), d); check("R6", "prev0 saved", d, 'h5C);
   endtask

   task automatic t_event_vs_csr;
      int d;
      @(negedge clk);
      ret_valid = 1'b1; ret_level = 2'd1;
      csr_we = 1'b1; csr_addr = ix(0, 0); csr_wdata = 'hEE;
      @(negedge clk);
      ret_valid = 1'b0; csr_we = 1'b0;
      check("R8", "ret beats CSR write to cur", cur_ns, 'h5C);
      check("R8", "priv", cur_priv, 1);
      @(negedge clk);
      trap_valid = 1'b1; trap_level = 2'd1; trap_cause = 5'd2;
      csr_we = 1'b1; csr_addr = ix(2, 1); csr_wdata = 'hAB;
      @(negedge clk);
      trap_valid = 1'b0; csr_we = 1'b0;
      check("R8", "trap uses old handler ns", cur_ns, 'h22);
      csr_rd(ix(2, 1), d); check("R8", "trap1 write dropped", d, 'h22);
   endtask

   task automatic t_bad_level;
      do_trap(3, 0);
      check("R9", "trap to absent level: priv", cur_priv, 1);
      check("R9", "trap to absent level: ns", cur_ns, 'h22);
      check("R9", "trap to absent level: mem_req", mem_req, 0);
      do_ret(3);
      check("R9", "ret to absent level: priv", cur_priv, 1);
      check("R9", "ret to absent level: ns", cur_ns, 'h22);
   endtask

   task automatic t_table_max_cause;
      csr_wr(ix(3, 1), 'h0FF0);
      do_trap(1, 31);
      check("R4", "mem_addr max cause", mem_addr, 'h106C);
      @(negedge clk);
      mem_ack = 1'b1; mem_rdata = 'h3D;
      @(negedge clk);
      mem_ack = 1'b0;
      check("R4", "cur_ns max cause", cur_ns, 'h3D);
      check("R4", "busy cleared", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_csr_map;
      t_trap_direct;
      t_ret;
      t_trap_equal;
      t_table;
      t_same_cycle;
      t_event_vs_csr;
      t_bad_level;
      t_table_max_cause;
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule